// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two IEEE-754 operands, both in single or both in double precision, and reduces the comparison to one condition bit. A four-bit code selects one of sixteen predicates. The condition bit is meant to feed the condition flag of a floating-point coprocessor. An invalid-operation flag comes out next to it. Arithmetic, trapping and storage of the condition flag are left to the blocks around this one.

Every predicate is a logical OR of up to three base relations: unordered, equal and less-than. The low three code bits choose which relations take part. The top code bit marks the signalling group, which raises invalid whenever a NaN is present. The result and the flag are registered and appear with a done strobe one cycle after the valid strobe.

Top module: `fcmp_pred_unit`

## Requirements
- R1: A request with `in_valid` high at a clock edge produces `out_done` high for exactly the following cycle. Without a request, `out_done` is low and `out_cond` and `out_invalid` keep their last values.
- R2: Code bit 0 adds the unordered relation, bit 1 adds equal and bit 2 adds less-than (a < b). `out_cond` is the OR of the selected relations, so codes 0 and 8 always give a false condition.
- R3: An operand is a NaN when its exponent field is all ones and its fraction is non-zero. With `in_dbl`=0 the sign is bit 31, the exponent bits 30:23 and the fraction bits 22:0. With `in_dbl`=1 the sign is bit 63, the exponent bits 62:52 and the fraction bits 51:0. An infinity is not a NaN.
- R4: Codes 0 to 7 never raise `out_invalid`, even when an operand is a NaN.
- R5: Codes 8 to 15 raise `out_invalid` exactly when at least one operand is a NaN. This includes code 8, whose condition is still false.
- R6: The equal and less-than relations are false when the operands are unordered, even for identical NaN bit patterns.
- R7: +0 and -0 compare equal, and neither is less than the other.
- R8: Less-than follows numeric order. Any negative non-zero value is below any positive value, a larger magnitude is below a smaller one when both are negative, and the infinities are the extremes.
- R9: In single precision, operand bits 63:32 have no effect on the result.
- R10: Reset, active high and synchronous, clears `out_done`, `out_cond` and `out_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_dbl | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| in_cond | input | 4 | Predicate code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_done | output | 1 | Result strobe, one cycle after the request |
| out_cond | output | 1 | Predicate result |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The path is one register stage deep, so a faulty classification or relation shows at the ports on the cycle after the offending request. It appears as a wrong `out_cond` or `out_invalid` for the specific operand pair and code. Sweeping every code over a grid of zeros, infinities, NaNs, denormals and ordinary values of both signs exposes a misplaced field or a swapped sign rule within one sweep. A stale output register shows up when the outputs change during idle cycles or when `out_done` appears without a request.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Format geometry
    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;
    localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
    localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
    localparam int MAG_W   = DP_W - 1;
    localparam int CODE_W  = 4;

    // Classified operand
    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    // Base relations between two operands
    typedef struct packed {
        logic un;
        logic eq;
        logic lt;
    } rel_t;

    // Predicate code; bit positions are behaviour
    typedef struct packed {
        logic sig;     // bit 3
        logic use_lt;  // bit 2
        logic use_eq;  // bit 1
        logic use_un;  // bit 0
    } code_t;

    typedef struct packed {
        logic cond;
        logic invalid;
    } verdict_t;

    function automatic logic all_ones_nz(input logic exp_ones, input logic frac_nz);
        return exp_ones & frac_nz;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int S_EXP  = SP_EXP,
    parameter int S_FRAC = SP_FRAC,
    parameter int D_EXP  = DP_EXP,
    parameter int D_FRAC = DP_FRAC
) (
    input  logic                          dbl,
    input  logic [D_EXP+D_FRAC:0]         raw,
    output opnd_t                         info
);
    localparam int SW = 1 + S_EXP + S_FRAC;
    localparam int DW = 1 + D_EXP + D_FRAC;
    localparam int PAD = (DW - 1) - (SW - 1);

    logic [S_EXP-1:0]  s_exp;
    logic [S_FRAC-1:0] s_frac;
    logic [D_EXP-1:0]  d_exp;
    logic [D_FRAC-1:0] d_frac;

    assign s_exp  = raw[SW-2 -: S_EXP];
    assign s_frac = raw[S_FRAC-1:0];
    assign d_exp  = raw[DW-2 -: D_EXP];
    assign d_frac = raw[D_FRAC-1:0];

    always_comb begin
        if (dbl) begin
            info.sign = raw[DW-1];
            info.nan  = all_ones_nz(&d_exp, |d_frac);
            info.zero = ~|raw[DW-2:0];
            info.mag  = raw[DW-2:0];
        end else begin
            info.sign = raw[SW-1];
            info.nan  = all_ones_nz(&s_exp, |s_frac);
            info.zero = ~|raw[SW-2:0];
            info.mag  = {{PAD{1'b0}}, raw[SW-2:0]};
        end
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output rel_t  rel
);
    logic unord, both_zero, mag_lt, mag_gt, mag_eq, ord_lt;

    assign unord     = a.nan | b.nan;
    assign both_zero = a.zero & b.zero;
    assign mag_lt    = a.mag < b.mag;
    assign mag_gt    = b.mag < a.mag;
    assign mag_eq    = a.mag == b.mag;

    always_comb begin
        unique case ({a.sign, b.sign})
            2'b00:   ord_lt = mag_lt;
            2'b11:   ord_lt = mag_gt;
            2'b10:   ord_lt = ~both_zero;
            default: ord_lt = 1'b0;
        endcase
    end

    assign rel.un = unord;
    assign rel.eq = ~unord & (both_zero | (a.sign == b.sign && mag_eq));
    assign rel.lt = ~unord & ord_lt;
endmodule

// File: rtl/fcmp_select.sv
module fcmp_select
    import fcmp_pkg::*;
(
    input  code_t    code,
    input  rel_t     rel,
    output verdict_t vd
);
    assign vd.cond    = (code.use_un & rel.un) |
                        (code.use_eq & rel.eq) |
                        (code.use_lt & rel.lt);
    assign vd.invalid = code.sig & rel.un;
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
    import fcmp_pkg::*;
#(
    parameter int OP_W = DP_W,
    parameter int CW   = CODE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_dbl,
    input  logic [CW-1:0]   in_cond,
    input  logic [OP_W-1:0] in_a,
    input  logic [OP_W-1:0] in_b,
    output logic            out_done,
    output logic            out_cond,
    output logic            out_invalid
);
    opnd_t    info [2];
    rel_t     rel;
    verdict_t vd;
    verdict_t vd_q;
    logic     done_q;

    logic [OP_W-1:0] ops [2];
    assign ops[0] = in_a;
    assign ops[1] = in_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify u_cls (
            .dbl  (in_dbl),
            .raw  (ops[i]),
            .info (info[i])
        );
    end

    fcmp_relate u_rel (
        .a   (info[0]),
        .b   (info[1]),
        .rel (rel)
    );

    fcmp_select u_sel (
        .code (code_t'(in_cond)),
        .rel  (rel),
        .vd   (vd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            vd_q   <= '0;
        end else begin
            done_q <= in_valid;
            if (in_valid) vd_q <= vd;
        end
    end

    assign out_done    = done_q;
    assign out_cond    = vd_q.cond;
    assign out_invalid = vd_q.invalid;
endmodule

module fcmp_pred_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [3:0] in_cond,
    input logic       out_done,
    input logic       out_cond,
    input logic       out_invalid
);
    a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);
    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);
    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_cond) && $stable(out_invalid)));
    a_r2_false_codes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cond[2:0] == 3'b000) |=> !out_cond);
    a_r4_quiet_never_invalid: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_cond[3]) |=> !out_invalid);
    a_r6_unordered_or_true: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cond[0]) |=> (!out_invalid || out_cond));
    a_r5_invalid_with_done: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cond[3] == 1'b0) |=> (out_done && !out_invalid));
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_done && !out_cond && !out_invalid));
endmodule

bind fcmp_pred_unit fcmp_pred_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_cond     (in_cond),
    .out_done    (out_done),
    .out_cond    (out_cond),
    .out_invalid (out_invalid)
);

// File: tb/sim_fcmp_pred_unit.sv
module sim_fcmp_pred_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [3:0]  in_cond = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_done, out_cond, out_invalid;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] exp_q [$];
    string      tag_q [$];
    logic [1:0] last_exp = 2'b00;
    bit         finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    fcmp_pred_unit u0 (.*);

    function automatic logic is_nan(input logic dbl, input logic [63:0] v);
        if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic logic signed [32:0] key32(input logic [31:0] v);
        logic signed [32:0] m;
        m = {2'b00, v[30:0]};
        return v[31] ? -m : m;
    endfunction

    function automatic logic [1:0] model(input logic dbl, input logic [63:0] a,
                                         input logic [63:0] b, input logic [3:0] c);
        logic un, eq, lt;
        un = is_nan(dbl, a) | is_nan(dbl, b);
        if (un) begin
            eq = 0; lt = 0;
        end else if (dbl) begin
            eq = ($bitstoreal(a) == $bitstoreal(b));
            lt = ($bitstoreal(a) <  $bitstoreal(b));
        end else begin
            eq = (key32(a[31:0]) == key32(b[31:0]));
            lt = (key32(a[31:0]) <  key32(b[31:0]));
        end
        return {(c[0] & un) | (c[1] & eq) | (c[2] & lt), c[3] & un};
    endfunction

    function automatic string pick_tag(input logic dbl, input logic [63:0] a,
                                       input logic [63:0] b, input logic [3:0] c);
        logic un;
        un = is_nan(dbl, a) | is_nan(dbl, b);
        if (c[3]) return "R5";
        if (un) return "R4";
        if (dbl ? (a[62:0] == 0 && b[62:0] == 0) : (a[30:0] == 0 && b[30:0] == 0))
            return "R7";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got cond/inv=%b expected %b", tag, act, exp_v);
        end
    endtask

    task automatic send(input logic dbl, input logic [63:0] a, input logic [63:0] b,
                        input logic [3:0] c, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_a = a; in_b = b; in_cond = c;
        exp_q.push_back(model(dbl, a, b, c));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare on each result strobe
    always @(negedge clk) begin
        if (!rst && out_done) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R1: done without request, got 1 expected 0");
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(t, {out_cond, out_invalid}, e);
            end
        end
    end

    logic [31:0] sv [11];
    logic [63:0] dv [10];

    initial begin
        sv = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
               32'h4000_0000, 32'hC000_0000, 32'h7F80_0000, 32'hFF80_0000,
               32'h7FC0_0000, 32'h7F80_0001, 32'h0000_0001};
        dv = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
               64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000,
               64'hC000_0000_0000_0000, 64'h7FF0_0000_0000_0000,
               64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0000,
               64'h7FF0_0000_0000_0001};

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        n_cmp++;
        if ({out_done, out_cond, out_invalid} !== 3'b000) begin
            n_bad++;
            $display("FAIL R10: got %b expected 000", {out_done, out_cond, out_invalid});
        end
        rst = 1'b0;
        idle(2);

        for (int i = 0; i < 11; i++)
            for (int j = 0; j < 11; j++)
                for (int c = 0; c < 16; c++)
                    send(1'b0, {32'h0, sv[i]}, {32'h0, sv[j]}, 4'(c),
                         pick_tag(1'b0, {32'h0, sv[i]}, {32'h0, sv[j]}, 4'(c)));
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                for (int c = 0; c < 16; c++)
                    send(1'b1, dv[i], dv[j], 4'(c), pick_tag(1'b1, dv[i], dv[j], 4'(c)));

        // Directed corner cases
        send(1'b0, 64'hC000_0000, 64'hBF80_0000, 4'd4, "R8");   // -2 < -1
        send(1'b0, 64'hFF80_0000, 64'hC000_0000, 4'd4, "R8");   // -inf < -2
        send(1'b1, dv[3], dv[0], 4'd4, "R8");                   // -1 < +0
        send(1'b1, dv[9], dv[2], 4'd9, "R3");                   // NaN low fraction bit
        send(1'b1, dv[6], dv[6], 4'd2, "R3");                   // inf == inf, not NaN
        send(1'b1, dv[8], dv[8], 4'd6, "R6");                   // same NaN bits, le false
        send(1'b0, 64'h7FF8_0000_3F80_0000, 64'h0000_0000_3F80_0000, 4'd10, "R9");
        send(1'b0, 64'h0000_0000_3F80_0000, 64'hFFFF_FFFF_4000_0000, 4'd4, "R9");
        send(1'b0, 64'h7F80_0001, 64'h3F80_0000, 4'd8, "R5");   // code 8 on NaN
        send(1'b0, 64'h8000_0000, 64'h0000_0000, 4'd6, "R7");
        idle(4);

        // R1: outputs hold, no strobe while idle
        n_cmp++;
        if (out_done !== 1'b0 || {out_cond, out_invalid} !== last_exp) begin
            n_bad++;
            $display("FAIL R1: idle got done=%b cond/inv=%b expected 0/%b",
                     out_done, {out_cond, out_invalid}, last_exp);
        end
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R1: watchdog expired, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule